// File: doc/BRIEF.md
# Quadrant Array Readout Address Sequencer

This block drives the readout of a square detector of 1024 by 1024 pixels that is split into four independent quadrants of 512 by 512. Each quadrant has eight video channels, so 32 samples are taken at once. A start pulse begins a full-frame read. For every pixel step the block raises a single convert strobe shared by all 32 converters. Along with the strobe it gives the 32 destination coordinates, so a downstream frame store can file each sample where it belongs.

The scan begins at the four outer corners and moves inward. Left quadrants sweep their columns toward the right and right quadrants sweep toward the left. Top quadrants move downward and bottom quadrants move upward, so the two middle rows are read last. Pixel dwell is a programmable number of clock cycles. A fast-mode select divides that dwell by four.

Top module: `quad_readout_seq`

## Requirements
- R1: After a synchronous reset, `busy`, `conv_strobe`, `row_adv` and `frame_done` are all 0.
- R2: A `start` sampled high while idle makes `busy` and `conv_strobe` high in the next cycle. The coordinates then show block 0 of row 0.
- R3: The effective dwell E is latched when the frame starts. Strobes are one cycle wide and come exactly E cycles apart. Outside fast mode, E equals `dwell`, and a `dwell` of 0 is treated as 1.
- R4: With `fast_mode` high at start, E = floor(`dwell`/4), but never less than 1.
- R5: Lane index i = q*8 + j, where q is the quadrant (0 top-left, 1 top-right, 2 bottom-left, 3 bottom-right) and j is the channel (0..7). The lane's x is at `x_out[i*10 +: 10]`. For block k, x is 8k+j in quadrants 0 and 2, and 1023-(8k+j) in quadrants 1 and 3.
- R6: For row count r (0-based), y is at `y_out[i*10 +: 10]`. It equals 1023-r in quadrants 0 and 1, and r in quadrants 2 and 3.
- R7: Step s maps to block k = s mod 64 and row r = s div 64. `row_adv` is high together with the strobe exactly at k = 0 for r > 0.
- R8: If the start was accepted at edge 0, a frame gives 64*512 strobes and `frame_done` is high for one cycle, 32768*E cycles after the first strobe. In that same cycle `busy` goes low.
- R9: A `start` that arrives while `busy` is high is ignored. The frame's length, its dwell and its coordinate order do not change.
- R10: Reset in the middle of a frame returns the block to idle in the next cycle. A later start then begins a fresh frame at block 0 of row 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Frame start request |
| dwell | input | DWELL_W | Pixel dwell in clock cycles |
| fast_mode | input | 1 | Divide dwell by four |
| busy | output | 1 | Frame in progress |
| conv_strobe | output | 1 | Common convert strobe for all lanes |
| row_adv | output | 1 | First strobe of a new row |
| frame_done | output | 1 | One-cycle end-of-frame pulse |
| x_out | output | 4*CHANNELS*COORD_W | Packed x coordinate per lane |
| y_out | output | 4*CHANNELS*COORD_W | Packed y coordinate per lane |

## Verification
The bench runs on a 64 by 64 array and checks every step of whole frames against coordinates it computes itself, so a quadrant with a wrong mirror or a row order that runs the wrong way shows up at the first strobe of that quadrant. The corner cases are:
- A dwell of 0 and a fast-mode dwell under 4: a design that lets E reach 0 would underflow its counter and stall.
- A dwell that is not a multiple of four: a design that rounds differently would shift the strobe spacing.
- A start pulse in the middle of a frame that also carries a different dwell: a design that does not ignore it would restart the frame or change its pacing.
- A reset in the middle of a frame: a design that leaves counters behind would make the next frame begin partway through.

// File: rtl/qrs_pkg.sv
package qrs_pkg;
  localparam int unsigned QUADS = 4;

  // quadrant indices: 0 top-left, 1 top-right, 2 bottom-left, 3 bottom-right
  function automatic logic quad_is_right(input int unsigned q);
    return (q == 1) || (q == 3);
  endfunction

  function automatic logic quad_is_top(input int unsigned q);
    return (q == 0) || (q == 1);
  endfunction
endpackage

// File: rtl/qrs_dwell.sv
module qrs_dwell #(
  parameter int unsigned DWELL_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic               run,
  input  logic [DWELL_W-1:0] dwell,
  input  logic               fast,
  output logic               expire
);
  logic [DWELL_W-1:0] raw, eff_in, eff_q, cnt_q;

  always_comb begin
    raw    = fast ? (dwell >> 2) : dwell;
    eff_in = (raw == '0) ? DWELL_W'(1) : raw;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      eff_q <= DWELL_W'(1);
      cnt_q <= '0;
    end else if (load) begin
      eff_q <= eff_in;
      cnt_q <= eff_in - DWELL_W'(1);
    end else if (run) begin
      cnt_q <= (cnt_q == '0) ? (eff_q - DWELL_W'(1)) : (cnt_q - DWELL_W'(1));
    end
  end

  assign expire = run && (cnt_q == '0);

  p_eff_nonzero_r4: assert property (@(posedge clk) disable iff (rst)
    eff_q != '0);
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
    cnt_q < eff_q);
  p_eff_held_r9: assert property (@(posedge clk) disable iff (rst)
    (run && !load) |=> $stable(eff_q));
endmodule

// File: rtl/qrs_scan.sv
module qrs_scan #(
  parameter int unsigned BLOCKS = 64,
  parameter int unsigned ROWS   = 512,
  parameter int unsigned BLK_W  = 6,
  parameter int unsigned ROW_W  = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             expire,
  output logic             accept,
  output logic             busy,
  output logic             strobe,
  output logic             row_adv,
  output logic             done,
  output logic [BLK_W-1:0] blk,
  output logic [ROW_W-1:0] row
);
  logic last_blk, last_step;

  assign accept    = start && !busy;
  assign last_blk  = (blk == BLK_W'(BLOCKS - 1));
  assign last_step = last_blk && (row == ROW_W'(ROWS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      strobe  <= 1'b0;
      row_adv <= 1'b0;
      done    <= 1'b0;
      blk     <= '0;
      row     <= '0;
    end else begin
      strobe  <= 1'b0;
      row_adv <= 1'b0;
      done    <= 1'b0;
      if (accept) begin
        busy   <= 1'b1;
        strobe <= 1'b1;
        blk    <= '0;
        row    <= '0;
      end else if (expire) begin
        if (last_step) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          strobe <= 1'b1;
          if (last_blk) begin
            blk     <= '0;
            row     <= row + ROW_W'(1);
            row_adv <= 1'b1;
          end else begin
            blk <= blk + BLK_W'(1);
          end
        end
      end
    end
  end

  p_strobe_in_frame_r2: assert property (@(posedge clk) disable iff (rst)
    strobe |-> busy);
  p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !expire) |=> ($stable(blk) && $stable(row)));
  p_row_adv_r7: assert property (@(posedge clk) disable iff (rst)
    row_adv |-> (strobe && blk == '0 && row != '0));
  p_reset_idle_r10: assert property (@(posedge clk)
    rst |=> (!busy && !strobe && !done));
endmodule

// File: rtl/qrs_coord.sv
module qrs_coord
  import qrs_pkg::*;
#(
  parameter int unsigned ARRAY_DIM = 1024,
  parameter int unsigned CHANNELS  = 8,
  parameter int unsigned COORD_W   = 10,
  parameter int unsigned BLK_W     = 6,
  parameter int unsigned ROW_W     = 9
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [BLK_W-1:0]                  blk,
  input  logic [ROW_W-1:0]                  row,
  output logic [QUADS*CHANNELS*COORD_W-1:0] x_flat,
  output logic [QUADS*CHANNELS*COORD_W-1:0] y_flat
);
  localparam logic [COORD_W-1:0] EDGE = COORD_W'(ARRAY_DIM - 1);

  logic [COORD_W-1:0] base_col, row_c;
  assign base_col = COORD_W'(blk) * COORD_W'(CHANNELS);
  assign row_c    = COORD_W'(row);

  for (genvar q = 0; q < QUADS; q++) begin : g_quad
    for (genvar j = 0; j < CHANNELS; j++) begin : g_lane
      localparam int unsigned LANE = q * CHANNELS + j;
      logic [COORD_W-1:0] col;
      assign col = base_col + COORD_W'(j);
      if (quad_is_right(q)) begin : g_right
        assign x_flat[LANE*COORD_W +: COORD_W] = EDGE - col;
      end else begin : g_left
        assign x_flat[LANE*COORD_W +: COORD_W] = col;
      end
      if (quad_is_top(q)) begin : g_top
        assign y_flat[LANE*COORD_W +: COORD_W] = EDGE - row_c;
      end else begin : g_bottom
        assign y_flat[LANE*COORD_W +: COORD_W] = row_c;
      end
    end
  end

  p_mirror_x_r5: assert property (@(posedge clk) disable iff (rst)
    (x_flat[0 +: COORD_W] + x_flat[CHANNELS*COORD_W +: COORD_W]) == EDGE);
  p_mirror_y_r6: assert property (@(posedge clk) disable iff (rst)
    (y_flat[0 +: COORD_W] + y_flat[2*CHANNELS*COORD_W +: COORD_W]) == EDGE);
endmodule

// File: rtl/quad_readout_seq.sv
module quad_readout_seq
  import qrs_pkg::*;
#(
  parameter int unsigned ARRAY_DIM = 1024,
  parameter int unsigned CHANNELS  = 8,
  parameter int unsigned DWELL_W   = 16,
  parameter int unsigned COORD_W   = $clog2(ARRAY_DIM)
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              start,
  input  logic [DWELL_W-1:0]                dwell,
  input  logic                              fast_mode,
  output logic                              busy,
  output logic                              conv_strobe,
  output logic                              row_adv,
  output logic                              frame_done,
  output logic [QUADS*CHANNELS*COORD_W-1:0] x_out,
  output logic [QUADS*CHANNELS*COORD_W-1:0] y_out
);
  localparam int unsigned QUAD_DIM = ARRAY_DIM / 2;
  localparam int unsigned BLOCKS   = QUAD_DIM / CHANNELS;
  localparam int unsigned ROWS     = QUAD_DIM;
  localparam int unsigned BLK_W    = (BLOCKS > 1) ? $clog2(BLOCKS) : 1;
  localparam int unsigned ROW_W    = (ROWS > 1) ? $clog2(ROWS) : 1;

  logic             accept, expire;
  logic [BLK_W-1:0] blk;
  logic [ROW_W-1:0] row;

  qrs_dwell #(.DWELL_W(DWELL_W)) u_dwell (
    .clk(clk), .rst(rst), .load(accept), .run(busy),
    .dwell(dwell), .fast(fast_mode), .expire(expire)
  );

  qrs_scan #(.BLOCKS(BLOCKS), .ROWS(ROWS), .BLK_W(BLK_W), .ROW_W(ROW_W)) u_scan (
    .clk(clk), .rst(rst), .start(start), .expire(expire),
    .accept(accept), .busy(busy), .strobe(conv_strobe), .row_adv(row_adv),
    .done(frame_done), .blk(blk), .row(row)
  );

  qrs_coord #(.ARRAY_DIM(ARRAY_DIM), .CHANNELS(CHANNELS), .COORD_W(COORD_W),
              .BLK_W(BLK_W), .ROW_W(ROW_W)) u_coord (
    .clk(clk), .rst(rst), .blk(blk), .row(row), .x_flat(x_out), .y_flat(y_out)
  );

  p_strobe_row_adv_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (conv_strobe && !row_adv));
endmodule

// File: tb/tb_quad_readout_seq.sv
module tb_quad_readout_seq;
  localparam int DIM = 64;
  localparam int CH  = 8;
  localparam int DW  = 8;
  localparam int CW  = $clog2(DIM);
  localparam int QD  = DIM / 2;
  localparam int BLK = QD / CH;
  localparam int NST = BLK * QD;
  localparam int LANES = 4 * CH;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, fast = 1'b0;
  logic [DW-1:0] dwell = '0;
  logic busy, strobe, radv, done;
  logic [LANES*CW-1:0] xo, yo;
  int tests = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  quad_readout_seq #(.ARRAY_DIM(DIM), .CHANNELS(CH), .DWELL_W(DW)) dut (
    .clk(clk), .rst(rst), .start(start), .dwell(dwell), .fast_mode(fast),
    .busy(busy), .conv_strobe(strobe), .row_adv(radv), .frame_done(done),
    .x_out(xo), .y_out(yo)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // one strobe step: all lanes against arithmetic coordinates (R5, R6)
  task automatic chk_coords(input int s);
    int k = s % BLK, r = s / BLK;
    bit bad = 0;
    int ax = 0, ex = 0;
    for (int q = 0; q < 4; q++)
      for (int j = 0; j < CH; j++) begin
        int i = q * CH + j;
        int exx = (q == 1 || q == 3) ? (DIM - 1 - (CH * k + j)) : (CH * k + j);
        int exy = (q < 2) ? (DIM - 1 - r) : r;
        int gx = int'(xo[i*CW +: CW]);
        int gy = int'(yo[i*CW +: CW]);
        if (!bad && (gx != exx || gy != exy)) begin
          bad = 1; ax = gx * 1000 + gy; ex = exx * 1000 + exy;
        end
      end
    chk("R5/R6", $sformatf("coords step %0d (x*1000+y)", s), ax, ex);
  endtask

  // run one frame; inj_at >= 0 pulses start with another dwell mid-frame (R9)
  task automatic run_frame(input int d, input bit f, input int eff, input int inj_at);
    int total = NST * eff;
    int strobes = 0;
    @(negedge clk); start = 1; dwell = DW'(d); fast = f;
    @(negedge clk); start = 0;
    chk("R2", "busy after start", busy, 1);
    for (int c = 0; c <= total; c++) begin
      int s = c / eff;
      bit es = (c < total) && (c % eff == 0);
      if (c == inj_at) begin start = 1; dwell = DW'(d + 5); fast = 0; end
      if (c == inj_at + 1) start = 0;
      if (strobe !== es) chk("R3", $sformatf("strobe cycle %0d", c), strobe, es);
      if (es) begin
        strobes++;
        chk_coords(s);
        chk("R7", $sformatf("row_adv step %0d", s), radv, (s % BLK == 0 && s >= BLK));
      end else if (radv) chk("R7", "row_adv without strobe", 1, 0);
      if (c < total && busy !== 1'b1) chk("R8", "busy dropped early", busy, 1);
      if (c < total && done) chk("R8", "early frame_done", 1, 0);
      if (c == total) begin
        chk("R8", "frame_done at end", done, 1);
        chk("R8", "busy low at end", busy, 0);
      end
      @(negedge clk);
    end
    chk("R8", "strobe count", strobes, NST);
    chk("R8", "frame_done one cycle", done, 0);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1", "busy", busy, 0);
    chk("R1", "strobe", strobe, 0);
    chk("R1", "row_adv", radv, 0);
    chk("R1", "frame_done", done, 0);
    // R2 first step is block 0 row 0 (checked inside), R3 dwell variants
    run_frame(1, 0, 1, -1);
    run_frame(3, 0, 3, -1);
    run_frame(0, 0, 1, -1);            // R3 dwell 0 acts as 1
    // R4 fast mode
    run_frame(10, 1, 2, -1);           // floor(10/4)=2
    run_frame(3, 1, 1, -1);            // floor(3/4)=0 -> 1
    run_frame(9, 1, 2, -1);
    // R9 start mid-frame ignored
    run_frame(2, 0, 2, 37);
    // R10 reset mid-frame
    @(negedge clk); start = 1; dwell = 2; fast = 0;
    @(negedge clk); start = 0;
    repeat (45) @(negedge clk);
    rst = 1;
    @(negedge clk); rst = 0;
    chk("R10", "busy after reset", busy, 0);
    chk("R10", "strobe after reset", strobe, 0);
    repeat (3) @(negedge clk);
    chk("R10", "still idle", busy, 0);
    run_frame(1, 0, 1, -1);            // R10 fresh frame from block 0 row 0
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule